// File: doc/BRIEF.md
# Address Bus Tenure Controller

This block runs one bus master's address tenure on a shared, split-transaction address bus. When a transaction request is pending, the block waits until four things hold at once: the arbiter grants the bus, the external busy input is low, its own tracked view of the bus is idle, and no other master is starting a transfer in the same cycle. It then opens a tenure. In the first cycle of the tenure it raises a one-cycle transfer-start pulse together with address-busy. It enables the transfer-start, address-busy, address and attribute drivers and holds them until the address acknowledge arrives. In the cycle after the acknowledge, all of them release together.

The block also watches the bus for other masters' work. A transfer-start that the block did not drive itself sets an internal busy flag, and an address acknowledge clears that flag. The same foreign start produces a one-cycle snoop-valid flag. When the block starts its own transfer, it raises an implied data-bus request, unless the transfer type decodes as address-only.

Top module: `addr_tenure_ctl`

## Requirements
- R1: A synchronous reset drives ts_o, busy_o, dbus_req_o, snoop_valid_o and trk_busy_o to 0 and disables every output enable (ts_oe_o, busy_oe_o, addr_oe_o, attr_oe_o) by the cycle after the reset edge, including when a tenure is in progress.
- R2: When, at a clock edge, req_i=1, grant_i=1, ext_busy_i=0, trk_busy_o=0, ts_in_i=0 (or ts_in_i only echoes the block's own start) and no tenure is open, a tenure opens. In the next cycle ts_o=1 and busy_o=1, and all four output enables are 1.
- R3: ts_o is high for exactly one cycle per tenure. busy_o and the enables stay high after ts_o falls.
- R4: When aack_i is sampled high during an open tenure, including in the transfer-start cycle, then in the next cycle busy_o=0 and ts_oe_o, busy_oe_o, addr_oe_o and attr_oe_o are all 0. Until then they stay 1.
- R5: While ext_busy_i=1, no tenure opens, even with a request and a grant present.
- R6: A foreign transfer-start sets trk_busy_o in the next cycle. An aack_i clears it in the next cycle. An aack_i in the same cycle as a foreign start wins, and the flag clears. While trk_busy_o=1, or while a foreign start is on ts_in_i, no tenure opens.
- R7: snoop_valid_o is 1 for exactly the cycle after ts_in_i=1. A ts_in_i that coincides with the block's own ts_o=1 does not raise it.
- R8: dbus_req_o pulses together with ts_o unless the own transfer type req_tt_i is address-only. Bit n of the parameter ADDR_ONLY_MASK marks code n as address-only. The default marks codes 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x18, so 0x02 and 0x0A request the data bus and 0x04 and 0x18 do not.
- R9: Without grant_i=1, or without req_i=1, no tenure opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Transaction request pending |
| req_tt_i | input | TT_W | Transfer type of the own request |
| grant_i | input | 1 | Address bus grant from the arbiter |
| ext_busy_i | input | 1 | External address-bus-busy from other masters |
| ts_in_i | input | 1 | Observed transfer-start on the bus |
| aack_i | input | 1 | Observed address acknowledge |
| ts_o | output | 1 | Driven transfer-start level |
| ts_oe_o | output | 1 | Transfer-start driver enable |
| busy_o | output | 1 | Driven address-busy level |
| busy_oe_o | output | 1 | Address-busy driver enable |
| addr_oe_o | output | 1 | Address lines driver enable |
| attr_oe_o | output | 1 | Attribute lines driver enable |
| dbus_req_o | output | 1 | Implied data-bus request |
| snoop_valid_o | output | 1 | Foreign address and attributes valid for snooping |
| trk_busy_o | output | 1 | Internally tracked bus-busy state |

## Verification
The start gate is driven with one blocking condition at a time. One pattern has only ext_busy_i high, one has no grant, one has the tracked busy set, and one has a foreign start colliding with the request. Each of these shows that its own blocker alone holds the tenure back.

Two acknowledge timings are tried: an acknowledge one cycle after the start, and an acknowledge in the start cycle itself. These separate the pulse width of ts_o from the release of the drivers.

A foreign start is contrasted with an echo of the block's own start. This shows that snoop flagging and busy tracking ignore the block's own traffic.

Two address-only codes and two data codes confirm the mask decode for the data-bus request.

// File: rtl/atc_pkg.sv
package atc_pkg;
  typedef enum logic [1:0] {
    TEN_IDLE = 2'd0,
    TEN_START = 2'd1,
    TEN_HOLD = 2'd2
  } tenure_state_e;
endpackage

// File: rtl/atc_tt_decode.sv
module atc_tt_decode #(
  parameter int TT_W = 5,
  parameter logic [(2**TT_W)-1:0] ADDR_ONLY_MASK = 32'h0101_1111
) (
  input  logic [TT_W-1:0] tt_i,
  output logic            addr_only_o
);
  localparam int N_CODES = 2 ** TT_W;

  logic [N_CODES-1:0] hit;

  for (genvar c = 0; c < N_CODES; c++) begin : g_code
    if (ADDR_ONLY_MASK[c]) begin : g_on
      assign hit[c] = (tt_i == TT_W'(c));
    end else begin : g_off
      assign hit[c] = 1'b0;
    end
  end

  assign addr_only_o = |hit;
endmodule

// File: rtl/atc_busy_track.sv
module atc_busy_track (
  input  logic clk,
  input  logic rst,
  input  logic ts_in_i,
  input  logic own_ts_i,
  input  logic aack_i,
  output logic foreign_ts_o,
  output logic trk_busy_o,
  output logic snoop_valid_o
);
  // A start seen while the block itself drives one is its own echo.
  assign foreign_ts_o = ts_in_i & ~own_ts_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      trk_busy_o    <= 1'b0;
      snoop_valid_o <= 1'b0;
    end else begin
      // An acknowledge in the same cycle closes the tenure it sees.
      trk_busy_o    <= (trk_busy_o | foreign_ts_o) & ~aack_i;
      snoop_valid_o <= foreign_ts_o;
    end
  end
endmodule

// File: rtl/atc_tenure_fsm.sv
module atc_tenure_fsm
  import atc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic grant_i,
  input  logic ext_busy_i,
  input  logic trk_busy_i,
  input  logic foreign_ts_i,
  input  logic aack_i,
  input  logic addr_only_i,
  output logic ts_o,
  output logic ts_oe_o,
  output logic busy_o,
  output logic busy_oe_o,
  output logic addr_oe_o,
  output logic attr_oe_o,
  output logic dbus_req_o
);
  tenure_state_e state_q, state_d;
  logic          launch;
  logic          hold_next;

  assign launch = (state_q == TEN_IDLE) & req_i & grant_i & ~ext_busy_i
                  & ~trk_busy_i & ~foreign_ts_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TEN_IDLE:  if (launch) state_d = TEN_START;
      TEN_START: state_d = aack_i ? TEN_IDLE : TEN_HOLD;
      TEN_HOLD:  if (aack_i) state_d = TEN_IDLE;
      default:   state_d = TEN_IDLE;
    endcase
  end

  assign hold_next = launch | ((state_q != TEN_IDLE) & ~aack_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= TEN_IDLE;
      ts_o       <= 1'b0;
      dbus_req_o <= 1'b0;
      ts_oe_o    <= 1'b0;
      busy_o     <= 1'b0;
      busy_oe_o  <= 1'b0;
      addr_oe_o  <= 1'b0;
      attr_oe_o  <= 1'b0;
    end else begin
      state_q    <= state_d;
      ts_o       <= launch;
      dbus_req_o <= launch & ~addr_only_i;
      ts_oe_o    <= hold_next;
      busy_o     <= hold_next;
      busy_oe_o  <= hold_next;
      addr_oe_o  <= hold_next;
      attr_oe_o  <= hold_next;
    end
  end
endmodule

// File: rtl/addr_tenure_ctl.sv
module addr_tenure_ctl #(
  parameter int TT_W = 5,
  parameter logic [(2**TT_W)-1:0] ADDR_ONLY_MASK = 32'h0101_1111
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  logic [TT_W-1:0] req_tt_i,
  input  logic            grant_i,
  input  logic            ext_busy_i,
  input  logic            ts_in_i,
  input  logic            aack_i,
  output logic            ts_o,
  output logic            ts_oe_o,
  output logic            busy_o,
  output logic            busy_oe_o,
  output logic            addr_oe_o,
  output logic            attr_oe_o,
  output logic            dbus_req_o,
  output logic            snoop_valid_o,
  output logic            trk_busy_o
);
  logic addr_only;
  logic foreign_ts;

  atc_tt_decode #(.TT_W(TT_W), .ADDR_ONLY_MASK(ADDR_ONLY_MASK)) u_dec (
    .tt_i        (req_tt_i),
    .addr_only_o (addr_only)
  );

  atc_busy_track u_trk (
    .clk           (clk),
    .rst           (rst),
    .ts_in_i       (ts_in_i),
    .own_ts_i      (ts_o),
    .aack_i        (aack_i),
    .foreign_ts_o  (foreign_ts),
    .trk_busy_o    (trk_busy_o),
    .snoop_valid_o (snoop_valid_o)
  );

  atc_tenure_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .req_i        (req_i),
    .grant_i      (grant_i),
    .ext_busy_i   (ext_busy_i),
    .trk_busy_i   (trk_busy_o),
    .foreign_ts_i (foreign_ts),
    .aack_i       (aack_i),
    .addr_only_i  (addr_only),
    .ts_o         (ts_o),
    .ts_oe_o      (ts_oe_o),
    .busy_o       (busy_o),
    .busy_oe_o    (busy_oe_o),
    .addr_oe_o    (addr_oe_o),
    .attr_oe_o    (attr_oe_o),
    .dbus_req_o   (dbus_req_o)
  );
endmodule

// File: rtl/atc_checker.sv
module atc_checker (
  input logic clk,
  input logic rst,
  input logic req_i,
  input logic grant_i,
  input logic ext_busy_i,
  input logic ts_in_i,
  input logic aack_i,
  input logic ts_o,
  input logic ts_oe_o,
  input logic busy_o,
  input logic busy_oe_o,
  input logic addr_oe_o,
  input logic attr_oe_o,
  input logic dbus_req_o,
  input logic snoop_valid_o,
  input logic trk_busy_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ts_o && !busy_o && !ts_oe_o && !busy_oe_o && !addr_oe_o
             && !attr_oe_o && !dbus_req_o && !snoop_valid_o && !trk_busy_o));

  p_start_drives_r2: assert property (@(posedge clk) disable iff (rst)
    ts_o |-> (busy_o && ts_oe_o && addr_oe_o && attr_oe_o));

  p_ts_single_r3: assert property (@(posedge clk) disable iff (rst)
    ts_o |=> !ts_o);

  p_release_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && aack_i) |=> (!busy_o && !ts_oe_o && !busy_oe_o && !addr_oe_o && !attr_oe_o));

  p_ext_busy_blocks_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && ext_busy_i) |=> !ts_o);

  p_track_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && trk_busy_o) |=> !ts_o);

  p_snoop_source_r7: assert property (@(posedge clk) disable iff (rst)
    snoop_valid_o |-> ($past(ts_in_i) && !$past(ts_o)));

  p_dbus_with_ts_r8: assert property (@(posedge clk) disable iff (rst)
    dbus_req_o |-> ts_o);

  p_need_grant_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && (!grant_i || !req_i)) |=> !ts_o);
endmodule

bind addr_tenure_ctl atc_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_i         (req_i),
  .grant_i       (grant_i),
  .ext_busy_i    (ext_busy_i),
  .ts_in_i       (ts_in_i),
  .aack_i        (aack_i),
  .ts_o          (ts_o),
  .ts_oe_o       (ts_oe_o),
  .busy_o        (busy_o),
  .busy_oe_o     (busy_oe_o),
  .addr_oe_o     (addr_oe_o),
  .attr_oe_o     (attr_oe_o),
  .dbus_req_o    (dbus_req_o),
  .snoop_valid_o (snoop_valid_o),
  .trk_busy_o    (trk_busy_o)
);

// File: tb/addr_tenure_ctl_test.sv
module addr_tenure_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 13;

  // {tag[3:0], req, grant, ext_busy, ts_in, aack, tt[4:0],
  //  exp ts, exp busy, exp oe, exp snoop, exp dbus, exp trk}
  localparam logic [19:0] VEC [N_VEC] = '{
    {4'd1, 5'b00000, 5'h00, 6'b000000}, // R1 idle after reset
    {4'd5, 5'b11100, 5'h02, 6'b000000}, // R5 ext busy holds back
    {4'd9, 5'b10000, 5'h02, 6'b000000}, // R9 no grant
    {4'd2, 5'b11000, 5'h02, 6'b111010}, // R2 start, data type
    {4'd3, 5'b00010, 5'h00, 6'b011000}, // R3 ts drops; own echo, R7 no snoop
    {4'd4, 5'b00001, 5'h00, 6'b000000}, // R4 release after aack
    {4'd7, 5'b00010, 5'h00, 6'b000101}, // R7 foreign start flagged
    {4'd6, 5'b11000, 5'h02, 6'b000001}, // R6 tracked busy blocks
    {4'd6, 5'b11001, 5'h02, 6'b000000}, // R6 aack clears tracked
    {4'd8, 5'b11000, 5'h04, 6'b111000}, // R8 address-only, no dbus
    {4'd4, 5'b00001, 5'h00, 6'b000000}, // R4 aack in start cycle
    {4'd6, 5'b11010, 5'h02, 6'b000101}, // R6 collision with foreign start
    {4'd6, 5'b00001, 5'h00, 6'b000000}  // R6 cleared again
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_i = 1'b0;
  logic [4:0] req_tt_i = '0;
  logic       grant_i = 1'b0;
  logic       ext_busy_i = 1'b0;
  logic       ts_in_i = 1'b0;
  logic       aack_i = 1'b0;
  logic       ts_o, ts_oe_o, busy_o, busy_oe_o, addr_oe_o, attr_oe_o;
  logic       dbus_req_o, snoop_valid_o, trk_busy_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  addr_tenure_ctl uut (
    .clk           (clk),
    .rst           (rst),
    .req_i         (req_i),
    .req_tt_i      (req_tt_i),
    .grant_i       (grant_i),
    .ext_busy_i    (ext_busy_i),
    .ts_in_i       (ts_in_i),
    .aack_i        (aack_i),
    .ts_o          (ts_o),
    .ts_oe_o       (ts_oe_o),
    .busy_o        (busy_o),
    .busy_oe_o     (busy_oe_o),
    .addr_oe_o     (addr_oe_o),
    .attr_oe_o     (attr_oe_o),
    .dbus_req_o    (dbus_req_o),
    .snoop_valid_o (snoop_valid_o),
    .trk_busy_o    (trk_busy_o)
  );

  task automatic drive(input logic [4:0] ctl, input logic [4:0] tt);
    {req_i, grant_i, ext_busy_i, ts_in_i, aack_i} = ctl;
    req_tt_i = tt;
  endtask

  task automatic chk(input string rq, input logic [5:0] exp);
    logic oe_bit;
    logic [5:0] got;
    oe_bit = exp[3] ? (ts_oe_o & busy_oe_o & addr_oe_o & attr_oe_o)
                    : (ts_oe_o | busy_oe_o | addr_oe_o | attr_oe_o);
    got = {ts_o, busy_o, oe_bit, snoop_valid_o, dbus_req_o, trk_busy_o};
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b expected=%b (ts,busy,oe,snoop,dbus,trk)", rq, got, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL R0 watchdog expired got=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", 6'b000000);

    for (int i = 0; i < N_VEC; i++) begin
      drive(VEC[i][15:11], VEC[i][10:6]);
      @(negedge clk);
      chk($sformatf("R%0d", VEC[i][19:16]), VEC[i][5:0]);
    end

    // R5: held back for two cycles, then starts once ext busy drops
    drive(5'b11100, 5'h18);
    @(negedge clk);
    chk("R5", 6'b000000);
    @(negedge clk);
    chk("R5", 6'b000000);
    drive(5'b11000, 5'h18);
    @(negedge clk);
    chk("R8", 6'b111000); // 0x18 is address-only
    drive(5'b00000, 5'h00);
    @(negedge clk);
    chk("R3", 6'b011000);
    @(negedge clk);
    chk("R4", 6'b011000); // no aack yet, drivers still held

    // R1: reset in the middle of a tenure
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", 6'b000000);

    // R8: code 0x0A requests the data bus; R2 fresh start after reset
    drive(5'b11000, 5'h0A);
    @(negedge clk);
    chk("R2", 6'b111010);
    drive(5'b00001, 5'h00);
    @(negedge clk);
    chk("R4", 6'b000000);

    // R1: tracked busy cleared by reset
    drive(5'b00010, 5'h00);
    @(negedge clk);
    chk("R6", 6'b000101);
    drive(5'b00000, 5'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", 6'b000000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule